// File: doc/BRIEF.md
# Six-input ADC scan sequencer with window comparator

This block sequences a single shared 10-bit converter core across six analog inputs. The CPU sets it up through 32-bit registers on a simple peripheral bus. It holds a control and status word, a mask of enabled inputs, a mask that marks which inputs are compared, and lower and upper bounds. It also exposes one read-only result word for each input.

Software writes the start bit. The block then requests one conversion after another, and each request names an input over a 3-bit index. It waits for the converter's done pulse and stores each returned sample. At the end of a pass it raises a sticky scan-complete flag. In one-shot mode the block stops after a single pass; in continuous mode it starts the next pass immediately. Clearing the start bit stops the block once the conversion already in flight has finished.

While compare mode is on, every new sample from a marked input is checked against the bounds. A sample outside the window raises a sticky out-of-window flag. Each flag has its own enable, and the two enabled flags are combined onto one interrupt line. No DMA request is produced.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, the control word reads 0, the enable mask (word offset 0x04) reads 0x3F, the compare mask (0x08), both bounds (lower 0x0C, upper 0x10) and all six result words (0x20 + 4·n) read 0, and `irq` is low.
- R2: The control word is at offset 0x00 and its bits are: 0 start, 1 continuous, 2 scan-irq enable, 3 scan flag, 4 compare mode, 5 compare-irq enable, 6 compare flag, 7 busy (read-only). Bits 31..8 read 0. Writing start=1 while idle sets busy on the next cycle.
- R3: A pass converts only the inputs whose enable-mask bit is 1, in ascending index order, and presents each index on `conv_chan` with a one-cycle `conv_start`.
- R4: The sample returned with `conv_done` is stored in the result word of the requested input, in bits 9..0 with the upper bits 0. Result words of inputs that are not converted keep their value.
- R5: If the enable mask is 0, a started pass ends without any conversion, sets the scan flag and releases busy.
- R6: In one-shot mode (continuous=0), busy clears, the start bit reads 0 and the scan flag sets after the last enabled input is stored.
- R7: In continuous mode, passes repeat without pause until start is written 0. After that write, at most one more conversion completes before busy clears.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 to it leaves the flag unchanged. A set flag stays set until it is cleared this way.
- R9: With compare mode on, a new sample from an input whose compare-mask bit is 1 sets the compare flag when it is strictly above the upper bound or strictly below the lower bound. Samples equal to a bound, samples from unmarked inputs, and any sample while compare mode is off leave the flag unchanged.
- R10: `irq` is high exactly while (scan flag and scan-irq enable) or (compare flag and compare-irq enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| conv_start | output | 1 | One-cycle request to the converter core |
| conv_chan | output | 3 | Input index for the request |
| conv_done | input | 1 | One-cycle completion from the converter core |
| conv_data | input | 10 | Sample that arrives with `conv_done` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses a sparse mask (inputs 1, 3 and 5). A sequencer that only increments would touch a disabled input, and a wrong skip would leave holes or write stale result words. The bench also tests an empty mask, where a design that waits for a first conversion would hang busy forever. For the comparator it places samples exactly on each bound, which exposes an off-by-one compare. It also feeds an out-of-range sample from an input that is not marked, which exposes a design that ignores the compare mask. Finally it stops continuous mode mid-pass: a design that drops the request in flight, or that keeps running, shows up in the count of conversions after the stop.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [1:0] {
      SCAN_IDLE  = 2'd0,
      SCAN_ISSUE = 2'd1,
      SCAN_WAIT  = 2'd2
   } scan_state_t;

   // control word bit positions (software-visible)
   localparam int unsigned CB_START  = 0;
   localparam int unsigned CB_CONT   = 1;
   localparam int unsigned CB_SIEN   = 2;
   localparam int unsigned CB_SFLAG  = 3;
   localparam int unsigned CB_CMODE  = 4;
   localparam int unsigned CB_CIEN   = 5;
   localparam int unsigned CB_CFLAG  = 6;
   localparam int unsigned CB_BUSY   = 7;

   // word offsets (byte address >> 2)
   localparam int unsigned W_CTRL  = 0;
   localparam int unsigned W_EN    = 1;
   localparam int unsigned W_CMSK  = 2;
   localparam int unsigned W_LOWER = 3;
   localparam int unsigned W_UPPER = 4;
   localparam int unsigned W_RES0  = 8;

endpackage

// File: rtl/adc_chan_picker.sv
module adc_chan_picker #(
   parameter int NCH = 6,
   parameter int CW  = 3,
   parameter int IW  = 4
) (
   input  logic [NCH-1:0] en_mask,
   input  logic [IW-1:0]  from_idx,
   output logic           found,
   output logic [CW-1:0]  chan
);

   // lowest enabled index that is not below from_idx
   always_comb begin
      found = 1'b0;
      chan  = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (en_mask[i] && (IW'(i) >= from_idx)) begin
            found = 1'b1;
            chan  = CW'(i);
         end
      end
   end

endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
   parameter int DW = 10
) (
   input  logic [DW-1:0] sample,
   input  logic [DW-1:0] lower,
   input  logic [DW-1:0] upper,
   output logic          outside
);

   assign outside = (sample > upper) || (sample < lower);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH = 6,
   parameter int DW  = 10,
   parameter int CW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [CW-1:0] wr_chan,
   input  logic [DW-1:0] wr_data,
   input  logic [CW-1:0] rd_chan,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] slot [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             slot[g] <= '0;
         else if (we && (wr_chan == CW'(g)))     slot[g] <= wr_data;
      end
   end

   assign rd_data = (int'(rd_chan) < NCH) ? slot[rd_chan] : '0;

   // R4: a stored sample is visible in its slot on the next cycle
   a_r4_sample_stored: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> slot[$past(wr_chan)] == $past(wr_data));

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NCH = 6,
   parameter int DW  = 10,
   parameter int AW  = 8,
   parameter int CW  = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          conv_start,
   output logic [CW-1:0] conv_chan,
   input  logic          conv_done,
   input  logic [DW-1:0] conv_data,
   output logic          irq
);

   localparam int IW = CW + 1;
   localparam int WW = AW - 2;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("adc_scan_ctrl: NCH out of range");
   end
   if (DW < 1 || DW > 31) begin : g_bad_dw
      $error("adc_scan_ctrl: DW out of range");
   end
   if (CW != $clog2(NCH)) begin : g_bad_cw
      $error("adc_scan_ctrl: CW must equal clog2(NCH)");
   end
   if ((1 << WW) < W_RES0 + NCH) begin : g_bad_aw
      $error("adc_scan_ctrl: AW too small for register map");
   end

   scan_state_t    state;
   logic           run, cont, sien, sflag, cmode, cien, cflag;
   logic [NCH-1:0] en_mask, cmp_mask;
   logic [DW-1:0]  lower_b, upper_b;
   logic [IW-1:0]  next_idx;
   logic [CW-1:0]  cur_ch;
   logic           start_q;

   logic [WW-1:0]  word;
   logic           wr_ctrl, busy;
   logic           pick_found;
   logic [CW-1:0]  pick_ch;
   logic           outside;
   logic           store;
   logic           pass_end;
   logic [CW-1:0]  res_sel;
   logic [DW-1:0]  res_q;

   assign word    = reg_addr[AW-1:2];
   assign wr_ctrl = reg_wr && (word == WW'(W_CTRL));
   assign busy    = (state != SCAN_IDLE);
   assign store   = (state == SCAN_WAIT) && conv_done;
   assign pass_end = (state == SCAN_ISSUE) && run && !pick_found;

   adc_chan_picker #(.NCH(NCH), .CW(CW), .IW(IW)) i_picker (
      .en_mask  (en_mask),
      .from_idx (next_idx),
      .found    (pick_found),
      .chan     (pick_ch)
   );

   adc_window_cmp #(.DW(DW)) i_window (
      .sample  (conv_data),
      .lower   (lower_b),
      .upper   (upper_b),
      .outside (outside)
   );

   assign res_sel = CW'(word - WW'(W_RES0));

   adc_result_bank #(.NCH(NCH), .DW(DW), .CW(CW)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (store),
      .wr_chan (cur_ch),
      .wr_data (conv_data),
      .rd_chan (res_sel),
      .rd_data (res_q)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cont     <= 1'b0;
         sien     <= 1'b0;
         cmode    <= 1'b0;
         cien     <= 1'b0;
         en_mask  <= '1;
         cmp_mask <= '0;
         lower_b  <= '0;
         upper_b  <= '0;
      end else if (reg_wr) begin
         case (int'(word))
            W_CTRL: begin
               cont  <= reg_wdata[CB_CONT];
               sien  <= reg_wdata[CB_SIEN];
               cmode <= reg_wdata[CB_CMODE];
               cien  <= reg_wdata[CB_CIEN];
            end
            W_EN:    en_mask  <= reg_wdata[NCH-1:0];
            W_CMSK:  cmp_mask <= reg_wdata[NCH-1:0];
            W_LOWER: lower_b  <= reg_wdata[DW-1:0];
            W_UPPER: upper_b  <= reg_wdata[DW-1:0];
            default: ;
         endcase
      end
   end

   // sticky flags: hardware set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sflag <= 1'b0;
         cflag <= 1'b0;
      end else begin
         if (pass_end)                                  sflag <= 1'b1;
         else if (wr_ctrl && reg_wdata[CB_SFLAG])       sflag <= 1'b0;
         if (store && cmode && cmp_mask[cur_ch] && outside) cflag <= 1'b1;
         else if (wr_ctrl && reg_wdata[CB_CFLAG])       cflag <= 1'b0;
      end
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SCAN_IDLE;
         run      <= 1'b0;
         next_idx <= '0;
         cur_ch   <= '0;
         start_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (wr_ctrl) run <= reg_wdata[CB_START];
         case (state)
            SCAN_IDLE: begin
               if (wr_ctrl && reg_wdata[CB_START]) begin
                  next_idx <= '0;
                  state    <= SCAN_ISSUE;
               end
            end
            SCAN_ISSUE: begin
               if (!run) begin
                  state <= SCAN_IDLE;
               end else if (pick_found) begin
                  cur_ch  <= pick_ch;
                  start_q <= 1'b1;
                  state   <= SCAN_WAIT;
               end else if (cont) begin
                  next_idx <= '0;
               end else begin
                  state <= SCAN_IDLE;
                  if (!wr_ctrl) run <= 1'b0;
               end
            end
            SCAN_WAIT: begin
               if (conv_done) begin
                  next_idx <= IW'(cur_ch) + IW'(1);
                  state    <= run ? SCAN_ISSUE : SCAN_IDLE;
               end
            end
            default: state <= SCAN_IDLE;
         endcase
      end
   end

   assign conv_start = start_q;
   assign conv_chan  = cur_ch;
   assign irq        = (sflag && sien) || (cflag && cien);

   // register read mux
   always_comb begin
      reg_rdata = '0;
      case (int'(word))
         W_CTRL: begin
            reg_rdata[CB_START] = run;
            reg_rdata[CB_CONT]  = cont;
            reg_rdata[CB_SIEN]  = sien;
            reg_rdata[CB_SFLAG] = sflag;
            reg_rdata[CB_CMODE] = cmode;
            reg_rdata[CB_CIEN]  = cien;
            reg_rdata[CB_CFLAG] = cflag;
            reg_rdata[CB_BUSY]  = busy;
         end
         W_EN:    reg_rdata[NCH-1:0] = en_mask;
         W_CMSK:  reg_rdata[NCH-1:0] = cmp_mask;
         W_LOWER: reg_rdata[DW-1:0]  = lower_b;
         W_UPPER: reg_rdata[DW-1:0]  = upper_b;
         default: begin
            if (int'(word) >= W_RES0 && int'(word) < W_RES0 + NCH)
               reg_rdata[DW-1:0] = res_q;
         end
      endcase
   end

   // R2: an idle start write makes the block busy next cycle
   a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[CB_START] && !busy) |=> busy);

   // R3: a request is a single-cycle pulse
   a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R8: flags hold unless software clears them
   a_r8_sflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sflag && !(wr_ctrl && reg_wdata[CB_SFLAG])) |=> sflag);
   a_r8_cflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cflag && !(wr_ctrl && reg_wdata[CB_CFLAG])) |=> cflag);

   // R9: the compare flag only rises when compare mode was on
   a_r9_cflag_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cflag) |-> $past(cmode));

   // R6: busy never falls while start remains set by hardware
   a_r6_release_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(wr_ctrl)) |-> !run);

endmodule

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        conv_start;
   logic [2:0]  conv_chan;
   logic        conv_done = 1'b0;
   logic [9:0]  conv_data = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [9:0] ain [6];
   int         log_ch [64];
   int         log_n = 0;

   always #2.5 clk = ~clk;

   adc_scan_ctrl i_adc_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
   );

   // converter model
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            automatic int ch = int'(conv_chan);
            if (log_n < 64) log_ch[log_n] = ch;
            log_n++;
            repeat (LAT) @(negedge clk);
            conv_data = ain[ch];
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(8'h00, v);
         if (!v[7]) return;
      end
      checks++; errors++;
      $display("FAIL R6: busy stuck, got 1 expected 0");
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); chk(v, 32'h0, "R1 ctrl");
      rd(8'h04, v); chk(v, 32'h3F, "R1 enable mask");
      rd(8'h08, v); chk(v, 32'h0, "R1 compare mask");
      rd(8'h0C, v); chk(v, 32'h0, "R1 lower");
      rd(8'h10, v); chk(v, 32'h0, "R1 upper");
      for (int n = 0; n < 6; n++) begin
         rd(8'h20 + 8'(4*n), v); chk(v, 32'h0, "R1 result");
      end
      chk({31'd0, irq}, 32'h0, "R1 irq");
   endtask

   task automatic t_oneshot_all();
      logic [31:0] v;
      int base;
      for (int n = 0; n < 6; n++) ain[n] = 10'(100 * n + 7);
      ain[5] = 10'h3FF;
      base = log_n;
      wr(8'h00, 32'h1);
      rd(8'h00, v); chk({31'd0, v[7]}, 32'h1, "R2 busy after start");
      wait_idle();
      chk(32'(log_n - base), 32'd6, "R3 conversion count");
      for (int n = 0; n < 6; n++) chk(32'(log_ch[base + n]), 32'(n), "R3 order");
      for (int n = 0; n < 6; n++) begin
         rd(8'h20 + 8'(4*n), v); chk(v, {22'd0, ain[n]}, "R4 result");
      end
      rd(8'h00, v); chk(v, 32'h08, "R6 one-shot end flag set start clear");
   endtask

   task automatic t_sparse();
      logic [31:0] v;
      int base;
      for (int n = 0; n < 6; n++) ain[n] = 10'(500 + n);
      wr(8'h00, 32'h08);          // clear scan flag
      wr(8'h04, 32'h2A);          // inputs 1,3,5
      base = log_n;
      wr(8'h00, 32'h1);
      wait_idle();
      chk(32'(log_n - base), 32'd3, "R3 sparse count");
      chk(32'(log_ch[base]),     32'd1, "R3 sparse first");
      chk(32'(log_ch[base + 1]), 32'd3, "R3 sparse second");
      chk(32'(log_ch[base + 2]), 32'd5, "R3 sparse third");
      rd(8'h24, v); chk(v, 32'd501, "R4 sparse stored");
      rd(8'h28, v); chk(v, 32'd207, "R4 disabled input kept");
      rd(8'h20, v); chk(v, 32'd7,   "R4 disabled input 0 kept");
   endtask

   task automatic t_empty();
      logic [31:0] v;
      int base;
      wr(8'h00, 32'h08);
      wr(8'h04, 32'h0);
      base = log_n;
      wr(8'h00, 32'h1);
      wait_idle();
      chk(32'(log_n - base), 32'd0, "R5 no conversions");
      rd(8'h00, v); chk(v, 32'h08, "R5 flag set, idle");
   endtask

   task automatic t_flags_irq();
      logic [31:0] v;
      wr(8'h00, 32'h04);          // enable scan irq, flag still set, write 0 to flag
      rd(8'h00, v); chk({31'd0, v[3]}, 32'h1, "R8 write 0 keeps flag");
      chk({31'd0, irq}, 32'h1, "R10 irq with flag and enable");
      wr(8'h00, 32'h00);
      chk({31'd0, irq}, 32'h0, "R10 irq masked");
      wr(8'h00, 32'h0C);          // clear with enable on
      rd(8'h00, v); chk({31'd0, v[3]}, 32'h0, "R8 write 1 clears flag");
      chk({31'd0, irq}, 32'h0, "R10 irq after clear");
   endtask

   task automatic t_compare();
      logic [31:0] v;
      wr(8'h04, 32'h0C);          // inputs 2,3
      wr(8'h08, 32'h04);          // compare input 2
      wr(8'h0C, 32'd100);
      wr(8'h10, 32'd200);
      ain[3] = 10'd999;           // unmarked, out of window
      ain[2] = 10'd200;           // on upper bound
      wr(8'h00, 32'h31);
      wait_idle();
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h0, "R9 equal upper/unmarked no flag");
      chk({31'd0, irq}, 32'h0, "R10 no compare irq");
      ain[2] = 10'd100;           // on lower bound
      wr(8'h00, 32'h31);
      wait_idle();
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h0, "R9 equal lower no flag");
      ain[2] = 10'd201;
      wr(8'h00, 32'h21);          // compare mode off
      wait_idle();
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h0, "R9 mode off no flag");
      wr(8'h00, 32'h31);
      wait_idle();
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h1, "R9 above upper sets flag");
      chk({31'd0, irq}, 32'h1, "R10 compare irq");
      wr(8'h00, 32'h70);
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h0, "R8 compare flag cleared");
      ain[2] = 10'd99;
      wr(8'h00, 32'h31);
      wait_idle();
      rd(8'h00, v); chk({31'd0, v[6]}, 32'h1, "R9 below lower sets flag");
      wr(8'h00, 32'h48);
   endtask

   task automatic t_continuous();
      logic [31:0] v;
      int at_stop;
      wr(8'h04, 32'h03);
      wr(8'h00, 32'h03);
      for (int i = 0; i < 3000 && (log_n < 64) && (log_n % 64 >= 0); i++) begin
         @(negedge clk);
         if (log_n >= 40) break;
      end
      rd(8'h00, v); chk({31'd0, v[7]}, 32'h1, "R7 still busy after passes");
      chk({31'd0, v[3]}, 32'h1, "R7 flag per pass");
      at_stop = log_n;
      wr(8'h00, 32'h02);
      wait_idle();
      checks++;
      if (log_n - at_stop > 1) begin
         errors++;
         $display("FAIL R7: conversions after stop got %0d expected <=1", log_n - at_stop);
      end
      chk(32'(log_ch[20]), 32'd0, "R7 pass wraps to input 0");
      chk(32'(log_ch[21]), 32'd1, "R7 pass order");
   endtask

   initial begin
      for (int n = 0; n < 6; n++) ain[n] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_oneshot_all();
      t_sparse();
      t_empty();
      t_flags_irq();
      t_compare();
      log_n = 0;
      t_continuous();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

endmodule